// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps one private, direct-mapped, write-back cache coherent with its peers on a shared snooping bus. Every line carries one of four coherence states (Invalid, Shared, Exclusive, Modified), a tag and one data word. Processor loads and stores arrive on a valid/ready request channel. Hits that need no bus traffic complete in the cycle they are presented. Misses, stores to shared lines and evictions of dirty lines raise a bus request and wait for the grant. Only the granted cycle changes the cache.

Transactions of other caches arrive on the snoop inputs. In the same cycle the controller answers with a shared indication and, for a dirty line, drives the block as a flush, which stands in for the memory reply. The shared response seen during the controller's own fill decides whether a read lands in Exclusive or in Shared. A later store to an Exclusive line therefore becomes Modified without using the bus.

Request channel rules: once `cpu_req_valid` is high, the requester keeps it high and keeps address, write flag and write data stable until the cycle in which `cpu_req_ready` is high. That cycle is the hand-over, and read data is valid only in that cycle. The requester sees back-pressure as `cpu_req_ready` held low while a bus transfer is pending or a snoop occupies the tag array.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: a snooped read of any address gets no shared and no flush response, and the first processor access to any address needs the bus.
- R2: A read that misses requests the bus with command code 1 (read) at the requested address. In the grant cycle it completes with `cpu_rsp_rdata` equal to `bus_fill_data`. The line fills to Exclusive when `bus_shared_in` is low and to Shared when it is high.
- R3: A write to a line that is absent or Invalid issues command code 2 (read-exclusive) at the requested address, completes in the grant cycle and leaves the line Modified holding the write data.
- R4: A write hit on an Exclusive or Modified line completes in the same cycle with no bus request and leaves the line Modified.
- R5: A write hit on a Shared line issues command code 3 (invalidate) at the line address, completes in the grant cycle and leaves the line Modified.
- R6: A read hit in Shared, Exclusive or Modified completes in the same cycle with the stored word and raises no bus request.
- R7: A miss whose direct-mapped slot holds a Modified line of another tag first issues command code 4 (write-back) with the victim's address (victim tag above the low index bits) and data, and does not complete. It then issues the read or read-exclusive for the new address.
- R8: A snooped read (code 1) that hits a Modified line drives `snp_flush` high with the stored word on `snp_data` and asserts `snp_shared`. The line becomes Shared, so a later local write needs an invalidate.
- R9: A snooped read that hits an Exclusive or Shared line asserts `snp_shared`, does not flush, and leaves the line Shared.
- R10: A snooped read-exclusive (code 2) or invalidate (code 3) that hits a valid line makes it Invalid, flushing the word first if the line was Modified. Snooped write-backs (code 4) and snoops that miss change nothing and assert neither response.
- R11: In a cycle with `snp_valid` high the processor side is stalled: no bus request and no completion.
- R12: A pending request is re-evaluated every cycle from the current line state. For example, a write waiting to invalidate a Shared line whose copy is snooped away issues a read-exclusive instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request completes this cycle |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_rdata | output | DATA_W | Load data, valid with ready on a load |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant; the transaction happens in the cycle it is high |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-exclusive, 3 invalidate, 4 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_fill_data | input | DATA_W | Fill word returned in the grant cycle |
| bus_shared_in | input | 1 | Another cache holds the block (wired shared line) |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 3 | Snooped command, same coding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped block |
| snp_flush | output | 1 | This cache supplies dirty data; memory reply is cancelled |
| snp_data | output | DATA_W | Flushed word |

## Verification
The assertions assume that the request fields stay steady while valid waits for ready. They also assume that the grant is never high in a cycle that carries a snoop, because the single bus cannot carry both the controller's transfer and another cache's transfer. The bench acts as the arbiter and peer caches. It raises the grant only at a falling edge after it has seen a request, and only in cycles it keeps free of snoops. It delivers snoops either between requests or while a request is waiting ungranted. Random traffic uses four tags on each of the four lines, so evictions, dirty write-backs and snoop hits in every state occur often.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  // CMD_NONE doubles as "hit, no bus needed" in the request decode
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_INV  = 3'd3,
    CMD_WB   = 3'd4
  } bus_cmd_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cpu_idx,
  output line_st_t          cpu_st,
  output logic [TAG_W-1:0]  cpu_tag,
  output logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_we,
  input  line_st_t          cpu_st_new,
  input  logic [TAG_W-1:0]  cpu_tag_new,
  input  logic              cpu_data_we,
  input  logic [DATA_W-1:0] cpu_data_new,
  input  logic [IDX_W-1:0]  snp_idx,
  output line_st_t          snp_st,
  output logic [TAG_W-1:0]  snp_tag,
  output logic [DATA_W-1:0] snp_data,
  input  logic              snp_we,
  input  line_st_t          snp_st_new
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    line_st_t          st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] data_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r   <= ST_I;
        tag_r  <= '0;
        data_r <= '0;
      end else if (snp_we && snp_idx == MY_IDX) begin
        st_r <= snp_st_new;
      end else if (cpu_we && cpu_idx == MY_IDX) begin
        st_r  <= cpu_st_new;
        tag_r <= cpu_tag_new;
        if (cpu_data_we) data_r <= cpu_data_new;
      end
    end

    assign st_q[i]   = st_r;
    assign tag_q[i]  = tag_r;
    assign data_q[i] = data_r;
  end

  assign cpu_st   = st_q[cpu_idx];
  assign cpu_tag  = tag_q[cpu_idx];
  assign cpu_data = data_q[cpu_idx];
  assign snp_st   = st_q[snp_idx];
  assign snp_tag  = tag_q[snp_idx];
  assign snp_data = data_q[snp_idx];

  // R11
  write_port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && snp_we));
endmodule

// File: rtl/mesi_req_decode.sv
module mesi_req_decode
  import mesi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  line_st_t         line_st,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_write,
  output bus_cmd_t         act
);
  logic hit;
  assign hit = (line_st != ST_I) && (line_tag == req_tag);

  always_comb begin
    if (hit) begin
      if (req_write && line_st == ST_S) act = CMD_INV;
      else                              act = CMD_NONE;
    end else if (line_st == ST_M) begin
      act = CMD_WB;
    end else begin
      act = req_write ? CMD_RDX : CMD_RD;
    end
  end
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_t          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              snp_shared,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data,
  output logic              st_we,
  output line_st_t          st_new
);
  logic hit, dirty;
  assign hit   = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
  assign dirty = hit && (line_st == ST_M);

  always_comb begin
    snp_shared = 1'b0;
    snp_flush  = 1'b0;
    st_we      = 1'b0;
    st_new     = ST_I;
    case (snp_cmd)
      3'(CMD_RD): begin
        snp_shared = hit;
        snp_flush  = dirty;
        st_we      = hit;
        st_new     = ST_S;
      end
      3'(CMD_RDX), 3'(CMD_INV): begin
        snp_flush = dirty;
        st_we     = hit;
        st_new    = ST_I;
      end
      default: ;
    endcase
  end

  assign snp_data = snp_flush ? line_data : '0;

  // R8
  flush_marks_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_flush && snp_cmd == 3'(CMD_RD)) |-> snp_shared);

  // R10
  kill_not_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd != 3'(CMD_RD)) |-> !snp_shared);
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  c_idx, s_idx;
  logic [TAG_W-1:0]  req_tag, s_req_tag, c_tag, s_tag;
  logic [DATA_W-1:0] c_data, s_data, c_data_new;
  line_st_t          c_st, s_st, c_st_new, s_st_new;
  logic              c_we, c_data_we, s_we;
  logic              cpu_go, need_bus, fire;
  bus_cmd_t          act;

  assign c_idx     = cpu_req_addr[IDX_W-1:0];
  assign req_tag   = cpu_req_addr[ADDR_W-1:IDX_W];
  assign s_idx     = snp_addr[IDX_W-1:0];
  assign s_req_tag = snp_addr[ADDR_W-1:IDX_W];

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk, .rst_n,
    .cpu_idx(c_idx), .cpu_st(c_st), .cpu_tag(c_tag), .cpu_data(c_data),
    .cpu_we(c_we), .cpu_st_new(c_st_new), .cpu_tag_new(req_tag),
    .cpu_data_we(c_data_we), .cpu_data_new(c_data_new),
    .snp_idx(s_idx), .snp_st(s_st), .snp_tag(s_tag), .snp_data(s_data),
    .snp_we(s_we), .snp_st_new(s_st_new)
  );

  mesi_req_decode #(.TAG_W(TAG_W)) u_dec (
    .line_st(c_st), .line_tag(c_tag), .req_tag(req_tag),
    .req_write(cpu_req_write), .act(act)
  );

  mesi_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snp (
    .clk, .rst_n,
    .snp_valid, .snp_cmd, .snp_tag(s_req_tag),
    .line_st(s_st), .line_tag(s_tag), .line_data(s_data),
    .snp_shared, .snp_flush, .snp_data,
    .st_we(s_we), .st_new(s_st_new)
  );

  // snoop owns the tag array this cycle; processor side waits
  assign cpu_go   = cpu_req_valid && !snp_valid;
  assign need_bus = (act != CMD_NONE);
  assign bus_req  = cpu_go && need_bus;
  assign fire     = bus_req && bus_gnt;
  assign bus_cmd  = bus_req ? 3'(act) : 3'(CMD_NONE);
  assign bus_addr = (act == CMD_WB) ? {c_tag, c_idx} : cpu_req_addr;
  assign bus_wdata = c_data;

  assign cpu_req_ready = cpu_go && (!need_bus || (bus_gnt && act != CMD_WB));
  assign cpu_rsp_rdata = (act == CMD_RD) ? bus_fill_data : c_data;

  assign c_we       = cpu_go && ((!need_bus && cpu_req_write) || fire);
  assign c_data_we  = (act != CMD_WB);
  assign c_data_new = cpu_req_write ? cpu_req_wdata : bus_fill_data;

  always_comb begin
    case (act)
      CMD_WB:  c_st_new = ST_I;
      CMD_RD:  c_st_new = bus_shared_in ? ST_S : ST_E;
      default: c_st_new = ST_M;
    endcase
  end

  // R11
  snoop_stalls_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!bus_req && !cpu_req_ready));

  // R11
  grant_no_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |-> !snp_valid);

  // R4
  silent_upgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_go && cpu_req_write && c_st == ST_E && c_tag == req_tag)
      |-> (cpu_req_ready && !bus_req));

  // R7
  wb_not_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && bus_cmd == 3'(CMD_WB)) |-> !cpu_req_ready);

  // R2
  fill_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && bus_cmd != 3'(CMD_WB)) |-> cpu_req_ready);
endmodule

// File: tb/mesi_snoop_ctrl_test.sv
module mesi_snoop_ctrl_test;
  localparam logic [2:0] C_NONE = 3'd0, C_RD = 3'd1, C_RDX = 3'd2,
                         C_INV = 3'd3, C_WB = 3'd4;
  localparam logic [1:0] MI = 2'd0, MS = 2'd1, ME = 2'd2, MM = 2'd3;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready, req_write = 0;
  logic [7:0]  req_addr = 0;
  logic [15:0] req_wdata = 0, rdata;
  logic        bus_req, gnt = 0, shared_in = 0;
  logic [2:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata, fill_data = 0;
  logic        snp_valid = 0;
  logic [2:0]  snp_cmd = 0;
  logic [7:0]  snp_addr = 0;
  logic        snp_shared, snp_flush;
  logic [15:0] snp_data;

  int checks = 0, errors = 0;
  logic [2:0]  last_cmd;
  logic [1:0]  m_st   [4];
  logic [5:0]  m_tag  [4];
  logic [15:0] m_data [4];

  always #4 clk = ~clk;

  mesi_snoop_ctrl uut (
    .clk, .rst_n,
    .cpu_req_valid(req_valid), .cpu_req_ready(req_ready), .cpu_req_write(req_write),
    .cpu_req_addr(req_addr), .cpu_req_wdata(req_wdata), .cpu_rsp_rdata(rdata),
    .bus_req, .bus_gnt(gnt), .bus_cmd, .bus_addr, .bus_wdata,
    .bus_fill_data(fill_data), .bus_shared_in(shared_in),
    .snp_valid, .snp_cmd, .snp_addr, .snp_shared, .snp_flush, .snp_data
  );

  task automatic check(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] model_act(input logic wr, input logic [7:0] a);
    logic [1:0] ix = a[1:0];
    logic hit = (m_st[ix] != MI) && (m_tag[ix] == a[7:2]);
    if (hit) return (wr && m_st[ix] == MS) ? C_INV : C_NONE;
    if (m_st[ix] == MM) return C_WB;
    return wr ? C_RDX : C_RD;
  endfunction

  function automatic string tag_of(input logic [2:0] ex, input logic wr);
    case (ex)
      C_NONE:  return wr ? "R4" : "R6";
      C_RD:    return "R2";
      C_RDX:   return "R3";
      C_INV:   return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic do_snoop(input logic [2:0] c, input logic [7:0] a);
    logic [1:0] ix = a[1:0];
    logic hit = (m_st[ix] != MI) && (m_tag[ix] == a[7:2]);
    logic ex_sh, ex_fl;
    string rq;
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1;
    ex_sh = (c == C_RD) && hit;
    ex_fl = (c == C_RD || c == C_RDX || c == C_INV) && hit && m_st[ix] == MM;
    rq = (c == C_RD) ? ((hit && m_st[ix] == MM) ? "R8" : "R9") : "R10";
    check(snp_shared == ex_sh && snp_flush == ex_fl, rq, {snp_shared, snp_flush}, {ex_sh, ex_fl});
    if (ex_fl) check(snp_data == m_data[ix], rq, snp_data, m_data[ix]);
    if (req_valid) check(!bus_req && !req_ready, "R11", {bus_req, req_ready}, 0);
    if (hit && c == C_RD) m_st[ix] = MS;
    if (hit && (c == C_RDX || c == C_INV)) m_st[ix] = MI;
  endtask

  task automatic snoop(input logic [2:0] c, input logic [7:0] a);
    @(negedge clk);
    do_snoop(c, a);
    @(negedge clk);
    snp_valid = 0; snp_cmd = 0;
  endtask

  task automatic cpu_op(input logic wr, input logic [7:0] a, input logic [15:0] wd,
                        input logic shr, input logic [15:0] fill,
                        input logic inj, input logic [2:0] icmd, input logic [7:0] iaddr);
    logic done = 0, pend = inj;
    logic [2:0] ex;
    logic [1:0] ix = a[1:0];
    logic [7:0] ea;
    string rq;
    int n = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    while (!done && n < 8) begin
      n++;
      #1;
      ex = model_act(wr, a);
      rq = tag_of(ex, wr);
      if (ex == C_NONE) begin
        check(req_ready && !bus_req, rq, {req_ready, bus_req}, 2'b10);
        if (!wr) check(rdata == m_data[ix], rq, rdata, m_data[ix]);
        else begin m_st[ix] = MM; m_data[ix] = wd; end
        last_cmd = C_NONE; done = 1;
      end else begin
        ea = (ex == C_WB) ? {m_tag[ix], ix} : a;
        check(bus_req && bus_cmd == ex, rq, bus_cmd, ex);
        check(bus_addr == ea, rq, bus_addr, ea);
        if (ex == C_WB) check(bus_wdata == m_data[ix], "R7", bus_wdata, m_data[ix]);
        if (pend) begin
          pend = 0;
          do_snoop(icmd, iaddr);
          @(negedge clk);
          snp_valid = 0; snp_cmd = 0;
        end else begin
          gnt = 1; shared_in = shr; fill_data = fill;
          #1;
          last_cmd = ex;
          if (ex == C_WB) begin
            check(!req_ready, "R7", req_ready, 0);
            m_st[ix] = MI;
            @(negedge clk);
            gnt = 0;
          end else begin
            check(req_ready, rq, req_ready, 1);
            if (ex == C_RD) begin
              check(rdata == fill, "R2", rdata, fill);
              m_st[ix] = shr ? MS : ME; m_data[ix] = fill;
            end else begin
              m_st[ix] = MM; m_data[ix] = wd;
            end
            m_tag[ix] = a[7:2];
            done = 1;
          end
        end
      end
    end
    if (!done) check(0, "R12", 0, 1);
    @(negedge clk);
    req_valid = 0; gnt = 0; shared_in = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 4; i++) begin m_st[i] = MI; m_tag[i] = 0; m_data[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle outputs and empty cache
    check(!bus_req && !req_ready && !snp_flush && !snp_shared, "R1",
          {bus_req, req_ready, snp_flush, snp_shared}, 0);
    snoop(C_RD, 8'h04);
    cpu_op(0, 8'h04, 0, 0, 16'h1111, 0, 0, 0);
    check(last_cmd == C_RD, "R1", last_cmd, C_RD);
    // R4: exclusive fill, silent upgrade
    cpu_op(1, 8'h04, 16'hAAAA, 0, 0, 0, 0, 0);
    check(last_cmd == C_NONE, "R4", last_cmd, C_NONE);
    cpu_op(0, 8'h04, 0, 0, 0, 0, 0, 0);
    // R8 then R5: flush makes it shared, write must invalidate
    snoop(C_RD, 8'h04);
    cpu_op(1, 8'h04, 16'hBBBB, 0, 0, 0, 0, 0);
    check(last_cmd == C_INV, "R5", last_cmd, C_INV);
    // R7: dirty victim evicted before fill
    cpu_op(0, 8'h08, 0, 0, 16'h2222, 0, 0, 0);
    // R10: invalidation from read-exclusive snoop
    cpu_op(0, 8'h01, 0, 1, 16'h3333, 0, 0, 0);
    snoop(C_RDX, 8'h01);
    cpu_op(0, 8'h01, 0, 0, 16'h3434, 0, 0, 0);
    check(last_cmd == C_RD, "R10", last_cmd, C_RD);
    // R12: shared line lost while waiting for grant
    cpu_op(0, 8'h02, 0, 1, 16'h4444, 0, 0, 0);
    cpu_op(1, 8'h02, 16'h5555, 0, 16'h0, 1, C_INV, 8'h02);
    check(last_cmd == C_RDX, "R12", last_cmd, C_RDX);
    // R9 then R5
    cpu_op(0, 8'h03, 0, 0, 16'h6666, 0, 0, 0);
    snoop(C_RD, 8'h03);
    cpu_op(1, 8'h03, 16'h7777, 0, 0, 0, 0, 0);
    check(last_cmd == C_INV, "R9", last_cmd, C_INV);
    // R10: missing snoop and write-back snoop leave the line alone
    snoop(C_RDX, 8'h07);
    snoop(C_WB, 8'h03);
    cpu_op(0, 8'h03, 0, 0, 0, 0, 0, 0);
    check(last_cmd == C_NONE, "R10", last_cmd, C_NONE);
    // R3: write miss on a free slot
    snoop(C_INV, 8'h01);
    cpu_op(1, 8'h05, 16'h8888, 0, 16'h0, 0, 0, 0);
    check(last_cmd == C_RDX, "R3", last_cmd, C_RDX);

    for (int k = 0; k < 400; k++) begin
      logic [7:0] ra = {4'd0, 4'($urandom % 16)};
      if ($urandom % 4 == 0)
        snoop(3'(1 + $urandom % 4), ra);
      else
        cpu_op(1'($urandom % 2), ra, 16'($urandom), 1'($urandom % 2), 16'($urandom),
               ($urandom % 5 == 0), 3'(1 + $urandom % 3), {4'd0, 4'($urandom % 16)});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule